// File: doc/BRIEF.md
# External video input receiver with timing recovery

This block receives a Y-Cb-Cr 4:2:2 video stream that enters the chip from outside, together with that stream's own clock and a sample-qualifier pin. The stream comes in one of two forms. In the narrow form a single 8-bit lane carries chroma and luma interleaved. In the wide form luma arrives on one 8-bit lane and chroma on a second one. The block is clocked by the incoming stream clock. It ignores every cycle on which the qualifier is low. It returns one luma sample and its matching chroma sample per valid strobe.

Line and frame timing comes from one of two places. It can come from two reference pins, one marking the active part of a line and one marking vertical blanking. It can also be recovered from the synchronisation words embedded in the luma lane. In the embedded case the field, vertical and horizontal bits are taken from the status word as they are, and its error-protection bits are not checked. The recovered flags leave the block next to the data. A source selector then chooses what reaches the output: the external stream, the chip's internal decoder stream, or a mix of the two decided pixel by pixel.

The output cannot apply back-pressure. The external source cannot be stalled, so the sink must accept every cycle on which `out_valid` is high. No ready input exists. Both the external and the internal paths reach the output with one register of latency.

Top module: `vip_xport_rx`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `out_valid`, `out_y`, `out_c`, `out_h`, `out_v` and `out_f` are all 0.
- R2: Wide mode (`cfg_wide`=1). Each qualified sample in the active region produces `out_valid`=1 one cycle later, with `out_y` equal to lane 0 and `out_c` equal to lane 1.
- R3: Narrow mode (`cfg_wide`=0). The active bytes of a line are taken in the order Cb, Y, Cr, Y. A strobe is produced only on the two Y bytes. The first Y is paired with the Cb before it and the second Y with the Cr before it. The phase restarts at Cb at the start of every line, which is the rising of `ref_h` in pin mode or an SAV in embedded mode.
- R4: A cycle with `in_qual`=0 produces no strobe. It does not advance the byte phase, the code detector or the timing flags.
- R5: Pin mode (`cfg_embedded`=0). The active region is where `ref_h`=1. On qualified cycles `out_h` follows the inverse of `ref_h` and `out_v` follows `ref_v`, one cycle later. `out_f` toggles on each qualified rising of `ref_v`.
- R6: Embedded mode (`cfg_embedded`=1). Three qualified lane-0 bytes FF, 00, 00 followed by a status byte form a timing code. One cycle after the status byte, `out_f`, `out_v` and `out_h` take its bits 6, 5 and 4. Bits 7 and 3..0 have no effect.
- R7: Embedded mode. A code with bit 4 = 0 (SAV) opens the active region and a code with bit 4 = 1 (EAV) closes it. No strobe is produced between an EAV and the next SAV. A lane-0 byte of 00 or FF is never emitted.
- R8: `src_sel` chooses the output: 00 internal, 01 external, 10 per pixel (`pix_sel`=1 external, 0 internal), 11 internal. The internal inputs `int_*` appear on the outputs one cycle later.
- R9: `cfg_out_width` encodes 00 = 8-bit, 01 = 16-bit, 10 = 24-bit. `cfg_err` is 1 exactly when `cfg_wide`=1 and `cfg_out_width`≠00. While it is 1, the external path produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External stream clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wide | input | 1 | 1 = two-lane input, 0 = byte-serial |
| cfg_embedded | input | 1 | 1 = timing from embedded codes, 0 = from reference pins |
| cfg_out_width | input | 2 | Configured output width (00/01/10 = 8/16/24 bit) |
| src_sel | input | 2 | Output source select |
| pix_sel | input | 1 | Per-pixel source choice in mode 10 |
| in_qual | input | 1 | Sample qualifier |
| in_lane0 | input | 8 | Luma or byte-serial lane |
| in_lane1 | input | 8 | Chroma lane in wide mode |
| ref_h | input | 1 | Horizontal reference, 1 = active line part |
| ref_v | input | 1 | Vertical reference, 1 = vertical blanking |
| int_valid | input | 1 | Internal stream strobe |
| int_y | input | 8 | Internal stream luma |
| int_c | input | 8 | Internal stream chroma |
| int_h | input | 1 | Internal stream H flag |
| int_v | input | 1 | Internal stream V flag |
| int_f | input | 1 | Internal stream field flag |
| out_valid | output | 1 | Output sample strobe |
| out_y | output | 8 | Output luma |
| out_c | output | 8 | Output chroma |
| out_h | output | 1 | Horizontal blanking flag |
| out_v | output | 1 | Vertical blanking flag |
| out_f | output | 1 | Field flag |
| cfg_err | output | 1 | Illegal width combination |

## Verification
The properties assume that the internal decoder stream is synchronous to the external stream clock. They also assume that the mode inputs change only between lines, so each sample is judged under the configuration present at its own edge. The stimulus keeps within these assumptions. It changes `cfg_*` only around a reset or between directed sequences, and it drives every input on the falling edge. In embedded mode the stimulus sends 00 and FF only inside timing codes, because the active-video bytes of a legal stream never take those values.

// File: rtl/vip_pkg.sv
`timescale 1ns/1ps
package vip_pkg;
  localparam int unsigned VIP_DW = 8;

  typedef enum logic [1:0] {
    SRC_INT = 2'b00,
    SRC_EXT = 2'b01,
    SRC_PIX = 2'b10,
    SRC_RSV = 2'b11
  } src_e;

  typedef struct packed {
    logic h;
    logic v;
    logic f;
  } flags_t;
endpackage

// File: rtl/vip_code_det.sv
`timescale 1ns/1ps
module vip_code_det #(
  parameter int unsigned DW = vip_pkg::VIP_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          qual,
  input  logic [DW-1:0] byte_i,
  output logic          hit,
  output logic          reserved,
  output vip_pkg::flags_t code
);
  localparam int unsigned HIST = 3;

  logic [DW-1:0] hist_q [HIST];

  // preamble: oldest all ones, the two younger all zero
  assign hit = qual && (hist_q[HIST-1] == '1) && (hist_q[1] == '0) && (hist_q[0] == '0);
  assign reserved = (byte_i == '1) || (byte_i == '0);
  assign code.f = byte_i[DW-2];
  assign code.v = byte_i[DW-3];
  assign code.h = byte_i[DW-4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HIST; i++) hist_q[i] <= '0;
    end else if (qual) begin
      hist_q[0] <= byte_i;
      for (int i = 1; i < HIST; i++) hist_q[i] <= hist_q[i-1];
    end
  end
endmodule

// File: rtl/vip_timing_track.sv
`timescale 1ns/1ps
module vip_timing_track (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            qual,
  input  logic            embedded,
  input  logic            ref_h,
  input  logic            ref_v,
  input  logic            hit,
  input  vip_pkg::flags_t code,
  output logic            active_now,
  output logic            restart,
  output vip_pkg::flags_t flags_next
);
  vip_pkg::flags_t st_q;
  logic act_q, refh_q, refv_q;

  always_comb begin
    flags_next = st_q;
    if (embedded) begin
      active_now = act_q & ~hit;
      restart    = 1'b0;
      if (hit) flags_next = code;
    end else begin
      active_now = ref_h;
      restart    = ref_h & ~refh_q;
      if (qual) begin
        flags_next.h = ~ref_h;
        flags_next.v = ref_v;
        flags_next.f = st_q.f ^ (ref_v & ~refv_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '{h: 1'b1, v: 1'b0, f: 1'b0};
      act_q  <= 1'b0;
      refh_q <= 1'b0;
      refv_q <= 1'b0;
    end else if (qual) begin
      st_q   <= flags_next;
      refh_q <= ref_h;
      refv_q <= ref_v;
      if (embedded && hit) act_q <= ~code.h;
    end
  end
endmodule

// File: rtl/vip_demux.sv
`timescale 1ns/1ps
module vip_demux #(
  parameter int unsigned DW = vip_pkg::VIP_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          qual,
  input  logic          wide,
  input  logic          embedded,
  input  logic          active_now,
  input  logic          restart,
  input  logic          hit,
  input  logic          reserved,
  input  logic          blocked,
  input  logic [DW-1:0] lane0,
  input  logic [DW-1:0] lane1,
  output logic          ext_valid,
  output logic [DW-1:0] ext_y,
  output logic [DW-1:0] ext_c
);
  localparam int unsigned PHASES = 4;
  localparam int unsigned PW = $clog2(PHASES);

  logic [PW-1:0] phase_q, ph_eff;
  logic [DW-1:0] cb_q, cr_q;
  logic take, drop;

  assign ph_eff = restart ? '0 : phase_q;
  assign take   = qual & active_now;
  assign drop   = embedded & reserved;

  always_comb begin
    if (wide) begin
      ext_valid = take & ~drop & ~blocked;
      ext_y     = lane0;
      ext_c     = lane1;
    end else begin
      ext_valid = take & ph_eff[0] & ~drop & ~blocked;
      ext_y     = lane0;
      ext_c     = ph_eff[1] ? cr_q : cb_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      cb_q    <= '0;
      cr_q    <= '0;
    end else if (qual) begin
      if (embedded && hit) begin
        phase_q <= '0;
      end else if (take) begin
        phase_q <= ph_eff + 1'b1;
        if (ph_eff == PW'(0)) cb_q <= lane0;
        if (ph_eff == PW'(2)) cr_q <= lane0;
      end
    end
  end
endmodule

// File: rtl/vip_out_mux.sv
`timescale 1ns/1ps
module vip_out_mux #(
  parameter int unsigned DW = vip_pkg::VIP_DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      src_sel,
  input  logic            pix_sel,
  input  logic            ext_valid,
  input  logic [DW-1:0]   ext_y,
  input  logic [DW-1:0]   ext_c,
  input  vip_pkg::flags_t ext_flags,
  input  logic            int_valid,
  input  logic [DW-1:0]   int_y,
  input  logic [DW-1:0]   int_c,
  input  vip_pkg::flags_t int_flags,
  output logic            out_valid,
  output logic [DW-1:0]   out_y,
  output logic [DW-1:0]   out_c,
  output vip_pkg::flags_t out_flags
);
  logic use_ext;

  always_comb begin
    case (src_sel)
      vip_pkg::SRC_EXT: use_ext = 1'b1;
      vip_pkg::SRC_PIX: use_ext = pix_sel;
      default:          use_ext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_y     <= '0;
      out_c     <= '0;
      out_flags <= '0;
    end else if (use_ext) begin
      out_valid <= ext_valid;
      out_y     <= ext_y;
      out_c     <= ext_c;
      out_flags <= ext_flags;
    end else begin
      out_valid <= int_valid;
      out_y     <= int_y;
      out_c     <= int_c;
      out_flags <= int_flags;
    end
  end
endmodule

// File: rtl/vip_xport_rx.sv
`timescale 1ns/1ps
module vip_xport_rx #(
  parameter int unsigned DW = vip_pkg::VIP_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wide,
  input  logic          cfg_embedded,
  input  logic [1:0]    cfg_out_width,
  input  logic [1:0]    src_sel,
  input  logic          pix_sel,
  input  logic          in_qual,
  input  logic [DW-1:0] in_lane0,
  input  logic [DW-1:0] in_lane1,
  input  logic          ref_h,
  input  logic          ref_v,
  input  logic          int_valid,
  input  logic [DW-1:0] int_y,
  input  logic [DW-1:0] int_c,
  input  logic          int_h,
  input  logic          int_v,
  input  logic          int_f,
  output logic          out_valid,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_c,
  output logic          out_h,
  output logic          out_v,
  output logic          out_f,
  output logic          cfg_err
);
  logic hit, reserved, active_now, restart, ext_valid;
  logic [DW-1:0] ext_y, ext_c;
  vip_pkg::flags_t code, ext_flags, int_flags, out_flags;

  assign cfg_err   = cfg_wide & (cfg_out_width != 2'b00);
  assign int_flags = '{h: int_h, v: int_v, f: int_f};
  assign out_h     = out_flags.h;
  assign out_v     = out_flags.v;
  assign out_f     = out_flags.f;

  vip_code_det #(.DW(DW)) u_det (
    .clk(clk), .rst_n(rst_n), .qual(in_qual), .byte_i(in_lane0),
    .hit(hit), .reserved(reserved), .code(code)
  );

  vip_timing_track u_trk (
    .clk(clk), .rst_n(rst_n), .qual(in_qual), .embedded(cfg_embedded),
    .ref_h(ref_h), .ref_v(ref_v), .hit(hit), .code(code),
    .active_now(active_now), .restart(restart), .flags_next(ext_flags)
  );

  vip_demux #(.DW(DW)) u_dmx (
    .clk(clk), .rst_n(rst_n), .qual(in_qual), .wide(cfg_wide),
    .embedded(cfg_embedded), .active_now(active_now), .restart(restart),
    .hit(hit), .reserved(reserved), .blocked(cfg_err),
    .lane0(in_lane0), .lane1(in_lane1),
    .ext_valid(ext_valid), .ext_y(ext_y), .ext_c(ext_c)
  );

  vip_out_mux #(.DW(DW)) u_mux (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .pix_sel(pix_sel),
    .ext_valid(ext_valid), .ext_y(ext_y), .ext_c(ext_c), .ext_flags(ext_flags),
    .int_valid(int_valid), .int_y(int_y), .int_c(int_c), .int_flags(int_flags),
    .out_valid(out_valid), .out_y(out_y), .out_c(out_c), .out_flags(out_flags)
  );
endmodule

// File: rtl/vip_xport_chk.sv
`timescale 1ns/1ps
module vip_xport_chk #(
  parameter int unsigned DW = vip_pkg::VIP_DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wide,
  input logic          cfg_embedded,
  input logic [1:0]    src_sel,
  input logic          in_qual,
  input logic [DW-1:0] in_lane0,
  input logic          int_valid,
  input logic [DW-1:0] int_y,
  input logic          out_valid,
  input logic [DW-1:0] out_y,
  input logic          cfg_err
);
  // R4
  noqual_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == vip_pkg::SRC_EXT && !in_qual) |=> !out_valid);

  // R9
  cfgerr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == vip_pkg::SRC_EXT && cfg_err) |=> !out_valid);

  // R9
  narrow_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wide |-> !cfg_err);

  // R7
  reserved_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == vip_pkg::SRC_EXT && cfg_embedded && in_qual &&
     (in_lane0 == '1 || in_lane0 == '0)) |=> !out_valid);

  // R8
  int_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == vip_pkg::SRC_INT) |=>
      (out_valid == $past(int_valid) && out_y == $past(int_y)));
endmodule

bind vip_xport_rx vip_xport_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_embedded(cfg_embedded),
  .src_sel(src_sel), .in_qual(in_qual), .in_lane0(in_lane0),
  .int_valid(int_valid), .int_y(int_y), .out_valid(out_valid),
  .out_y(out_y), .cfg_err(cfg_err)
);

// File: tb/sim_vip_xport_rx.sv
`timescale 1ns/1ps
module sim_vip_xport_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wide = 1'b0, cfg_embedded = 1'b0, pix_sel = 1'b0;
  logic [1:0] cfg_out_width = 2'b00, src_sel = 2'b01;
  logic in_qual = 1'b0, ref_h = 1'b0, ref_v = 1'b0;
  logic [7:0] in_lane0 = 8'h0, in_lane1 = 8'h0;
  logic int_valid = 1'b0, int_h = 1'b0, int_v = 1'b0, int_f = 1'b0;
  logic [7:0] int_y = 8'h0, int_c = 8'h0;
  logic out_valid, out_h, out_v, out_f, cfg_err;
  logic [7:0] out_y, out_c;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  vip_xport_rx u0 (.*);

  // {qual, lane0, exp_valid, exp_y, exp_c, exp_h, exp_v, exp_f}
  localparam int NV = 28;
  localparam logic [28:0] TBL [NV] = '{
    {1'b1, 8'hFF, 1'b0, 8'h00, 8'h00, 3'b100},
    {1'b1, 8'h00, 1'b0, 8'h00, 8'h00, 3'b100},
    {1'b0, 8'h55, 1'b0, 8'h00, 8'h00, 3'b100},
    {1'b1, 8'h00, 1'b0, 8'h00, 8'h00, 3'b100},
    {1'b1, 8'h8F, 1'b0, 8'h00, 8'h00, 3'b000},
    {1'b1, 8'h40, 1'b0, 8'h00, 8'h00, 3'b000},
    {1'b1, 8'h10, 1'b1, 8'h10, 8'h40, 3'b000},
    {1'b0, 8'h77, 1'b0, 8'h00, 8'h00, 3'b000},
    {1'b1, 8'h60, 1'b0, 8'h00, 8'h00, 3'b000},
    {1'b1, 8'h20, 1'b1, 8'h20, 8'h60, 3'b000},
    {1'b1, 8'h41, 1'b0, 8'h00, 8'h00, 3'b000},
    {1'b1, 8'h11, 1'b1, 8'h11, 8'h41, 3'b000},
    {1'b1, 8'h61, 1'b0, 8'h00, 8'h00, 3'b000},
    {1'b1, 8'h21, 1'b1, 8'h21, 8'h61, 3'b000},
    {1'b1, 8'hFF, 1'b0, 8'h00, 8'h00, 3'b000},
    {1'b1, 8'h00, 1'b0, 8'h00, 8'h00, 3'b000},
    {1'b1, 8'h00, 1'b0, 8'h00, 8'h00, 3'b000},
    {1'b1, 8'hB6, 1'b0, 8'h00, 8'h00, 3'b110},
    {1'b1, 8'h30, 1'b0, 8'h00, 8'h00, 3'b110},
    {1'b1, 8'h31, 1'b0, 8'h00, 8'h00, 3'b110},
    {1'b1, 8'hFF, 1'b0, 8'h00, 8'h00, 3'b110},
    {1'b1, 8'h00, 1'b0, 8'h00, 8'h00, 3'b110},
    {1'b1, 8'h00, 1'b0, 8'h00, 8'h00, 3'b110},
    {1'b1, 8'hC0, 1'b0, 8'h00, 8'h00, 3'b001},
    {1'b1, 8'h45, 1'b0, 8'h00, 8'h00, 3'b001},
    {1'b1, 8'h15, 1'b1, 8'h15, 8'h45, 3'b001},
    {1'b1, 8'h65, 1'b0, 8'h00, 8'h00, 3'b001},
    {1'b1, 8'h25, 1'b1, 8'h25, 8'h65, 3'b001}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic q, input logic [7:0] a, input logic [7:0] b,
                      input logic rh, input logic rv);
    @(negedge clk);
    in_qual = q; in_lane0 = a; in_lane1 = b; ref_h = rh; ref_v = rv;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_qual = 1'b0; ref_h = 1'b0; ref_v = 1'b0; int_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #800000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 out_valid", {7'b0, out_valid}, 8'h0);
    chk("R1 out_y", out_y, 8'h0);
    chk("R1 out_c", out_c, 8'h0);
    chk("R1 flags", {5'b0, out_h, out_v, out_f}, 8'h0);

    // vector walk: narrow embedded mode (R3 R4 R6 R7)
    cfg_wide = 1'b0; cfg_embedded = 1'b1; src_sel = 2'b01;
    do_reset();
    for (int i = 0; i < NV; i++) begin
      logic [28:0] e;
      e = TBL[i];
      step(e[28], e[27:20], 8'h00, 1'b0, 1'b0);
      chk($sformatf("R7 valid v%0d", i), {7'b0, out_valid}, {7'b0, e[19]});
      if (e[19]) begin
        chk($sformatf("R3 y v%0d", i), out_y, e[18:11]);
        chk($sformatf("R3 c v%0d", i), out_c, e[10:3]);
      end
      chk($sformatf("R6 hvf v%0d", i), {5'b0, out_h, out_v, out_f}, {5'b0, e[2:0]});
    end

    // R2 R5 wide pin mode
    cfg_wide = 1'b1; cfg_embedded = 1'b0; cfg_out_width = 2'b00;
    do_reset();
    step(1, 8'h12, 8'h34, 0, 0);
    chk("R5 blank valid", {7'b0, out_valid}, 8'h0);
    chk("R5 h blank", {7'b0, out_h}, 8'h1);
    step(1, 8'h12, 8'h34, 1, 0);
    chk("R2 valid", {7'b0, out_valid}, 8'h1);
    chk("R2 y", out_y, 8'h12);
    chk("R2 c", out_c, 8'h34);
    chk("R5 h active", {7'b0, out_h}, 8'h0);
    step(0, 8'h56, 8'h78, 1, 0);
    chk("R4 wide noqual", {7'b0, out_valid}, 8'h0);
    step(1, 8'h01, 8'h02, 0, 1);
    chk("R5 v rise", {6'b0, out_v, out_f}, 8'h3);
    step(1, 8'h01, 8'h02, 0, 1);
    chk("R5 v hold", {6'b0, out_v, out_f}, 8'h3);
    step(1, 8'h01, 8'h02, 0, 0);
    chk("R5 v fall", {6'b0, out_v, out_f}, 8'h1);
    step(1, 8'h01, 8'h02, 0, 1);
    chk("R5 f toggle", {6'b0, out_v, out_f}, 8'h2);

    // R3 narrow pin mode, line cut mid-group, phase restart
    cfg_wide = 1'b0;
    do_reset();
    step(1, 8'hA0, 8'h0, 1, 0);
    chk("R3 cb slot", {7'b0, out_valid}, 8'h0);
    step(1, 8'h11, 8'h0, 1, 0);
    chk("R3 y slot valid", {7'b0, out_valid}, 8'h1);
    chk("R3 y slot c", out_c, 8'hA0);
    step(1, 8'hA2, 8'h0, 1, 0);
    step(1, 8'h22, 8'h0, 0, 0);
    chk("R3 blank", {7'b0, out_valid}, 8'h0);
    step(1, 8'hB0, 8'h0, 1, 0);
    chk("R3 restart cb", {7'b0, out_valid}, 8'h0);
    step(1, 8'h33, 8'h0, 1, 0);
    chk("R3 restart y", out_y, 8'h33);
    chk("R3 restart c", out_c, 8'hB0);

    // R8 source selection
    cfg_wide = 1'b1;
    do_reset();
    @(negedge clk);
    int_valid = 1'b1; int_y = 8'h5A; int_c = 8'hA5; int_h = 1'b1; int_v = 1'b0; int_f = 1'b1;
    src_sel = 2'b00;
    step(1, 8'h77, 8'h88, 1, 0);
    chk("R8 int y", out_y, 8'h5A);
    chk("R8 int c", out_c, 8'hA5);
    chk("R8 int flags", {5'b0, out_h, out_v, out_f}, 8'h5);
    src_sel = 2'b10; pix_sel = 1'b0;
    step(1, 8'h77, 8'h88, 1, 0);
    chk("R8 pix int", out_y, 8'h5A);
    pix_sel = 1'b1;
    step(1, 8'h77, 8'h88, 1, 0);
    chk("R8 pix ext y", out_y, 8'h77);
    chk("R8 pix ext c", out_c, 8'h88);
    src_sel = 2'b11;
    step(1, 8'h77, 8'h88, 1, 0);
    chk("R8 sel11 int", out_y, 8'h5A);
    src_sel = 2'b01;
    @(negedge clk);
    int_valid = 1'b0;

    // R9 configuration error
    cfg_out_width = 2'b10;
    #1;
    chk("R9 err flag", {7'b0, cfg_err}, 8'h1);
    step(1, 8'h44, 8'h55, 1, 0);
    chk("R9 blocked", {7'b0, out_valid}, 8'h0);
    cfg_out_width = 2'b00;
    #1;
    chk("R9 err clear", {7'b0, cfg_err}, 8'h0);
    step(1, 8'h44, 8'h55, 1, 0);
    chk("R9 unblocked", {7'b0, out_valid}, 8'h1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule